// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

A register-mapped timer with several independent 32-bit up-counters. Each counter advances on a count clock chosen per channel from a slow reference clock, either undivided or divided by 8, 32 or 128 through one shared prescaler. When a counter equals its channel's compare value on a count tick, it returns to zero and raises a match flag. Each period therefore lasts compare+1 ticks. In one-shot mode the same event also stops the channel. A flag ANDed with the channel's enable and request-type fields drives that channel's interrupt line.

Software drives the block through a simple word bus with address, write data, a write strobe and combinational read data. All run bits live in one shared run-control word. Flags are cleared by writing them as zero. A write to a counter is held back until two slow-clock pulses have passed, which reflects the slow clock domain the count runs in.

Top module: `cmtimer_top`

## Requirements
- R1: After reset the run-control word, every control word and every counter read 0, every compare register reads 0xFFFFFFFF, and all interrupt lines are low.
- R2: Byte address 0x00 is the run-control word. Channel n's words sit at 0x10+0x10*n: control at +0x0, counter at +0x4, compare at +0x8. Every other address reads 0. In a control word only bits 8, 7, 5:4 and 2:0 are writable, and bits 15 and 14 are the flags. Other bits read 0.
- R3: Bit n of the run-control word runs channel n, and one write sets all the bits at once. A channel whose bit is 0 keeps its count. Setting the bit again resumes counting from that value.
- R4: Control bits 2:0 pick the count tick: 7 gives every slow pulse, 4 every 8th, 5 every 32nd and 6 every 128th. The divided ticks come from one free-running prescaler shared by all channels. Codes 0 to 3 give no tick.
- R5: A count tick with counter equal to compare loads 0 into the counter and sets bit 15 (match flag). A tick in any other case adds 1.
- R6: When bit 8 is 0 (one-shot), a match also clears the channel's run bit in the same cycle. This wins over a run-control write made in that cycle.
- R7: A tick with the counter at 0xFFFFFFFF and no match loads 0 and sets bit 14 (overflow flag).
- R8: The interrupt of channel n is high while bit 15 is 1, bit 7 is 1 and bits 5:4 equal 2. Any other request-type value keeps it low.
- R9: Writing 0 to a flag bit clears it and writing 1 has no effect. A flag set by hardware in the same cycle as a clearing write stays set.
- R10: A counter write takes effect on the second slow pulse after the write cycle. Until then reads return the old count, which keeps counting. The commit tick loads the value without incrementing it or testing it for a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow reference clock period |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
Two pairs of events can fall in one cycle. A software flag clear can meet a hardware match on the same edge. A pending counter load can commit on a slow pulse that would otherwise count. The bench times a clear-to-zero write to land exactly on a match edge and expects the flag to read back set. It also walks a counter write through idle and active slow pulses, expecting the old count until the second pulse and the loaded value, not value+1, after it. A behavioural model compares read data and interrupt lines on every clock.

// File: rtl/cmtimer_pkg.sv
// Shared field positions, clock-select codes and tick bundle for the
// compare-match timer. Assumes 32-bit bus words.
package cmtimer_pkg;
    localparam int CTL_MATCH = 15;
    localparam int CTL_OVFL  = 14;
    localparam int CTL_CONT  = 8;
    localparam int CTL_IEN   = 7;
    localparam int CTL_REQ   = 4;
    localparam logic [1:0] REQ_IRQ = 2'd2;

    typedef enum logic [2:0] {
        CKS_DIV8   = 3'd4,
        CKS_DIV32  = 3'd5,
        CKS_DIV128 = 3'd6,
        CKS_DIV1   = 3'd7
    } cks_e;

    typedef struct packed {
        logic div1;
        logic div8;
        logic div32;
        logic div128;
    } tick_set_t;
endpackage

// File: rtl/cmtimer_prescale.sv
// Shared prescaler: counts slow pulses and flags every 8th, 32nd and
// 128th one. Assumes slow_tick is a single-cycle pulse.
module cmtimer_prescale
    import cmtimer_pkg::*;
#(
    parameter int LOG_A = 3,
    parameter int LOG_B = 5,
    parameter int LOG_C = 7
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      slow_tick,
    output tick_set_t ticks
);
    localparam int PRE_W = LOG_C;

    logic [PRE_W-1:0] pre_q;

    // free-running pulse count, wraps at 2**PRE_W
    always_ff @(posedge clk) begin
        if (!rst_n)         pre_q <= '0;
        else if (slow_tick) pre_q <= pre_q + 1'b1;
    end

    // a divided tick fires on the last pulse of each group
    always_comb begin
        ticks.div1   = slow_tick;
        ticks.div8   = slow_tick && (&pre_q[LOG_A-1:0]);
        ticks.div32  = slow_tick && (&pre_q[LOG_B-1:0]);
        ticks.div128 = slow_tick && (&pre_q[LOG_C-1:0]);
    end
endmodule

// File: rtl/cmtimer_chan.sv
// One timer channel: control fields, flags, counter, compare and the
// delayed counter-load path. Assumes write strobes are pre-decoded and
// CNT_W <= DATA_W.
module cmtimer_chan
    import cmtimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tick_set_t         ticks,
    input  logic              slow_tick,
    input  logic              run,
    input  logic              wr_ctl,
    input  logic              wr_cnt,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_word,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              pend_q,
    output logic              irq,
    output logic              stop_req
);
    logic             cont_q, ien_q, match_q, ovfl_q, ph_q;
    logic [1:0]       req_q;
    logic [2:0]       cks_q;
    logic [CNT_W-1:0] pval_q;
    logic             sel_tick, commit, step, hit, wrap;

    // pick this channel's count tick
    always_comb begin
        case (cks_q)
            CKS_DIV1:   sel_tick = ticks.div1;
            CKS_DIV8:   sel_tick = ticks.div8;
            CKS_DIV32:  sel_tick = ticks.div32;
            CKS_DIV128: sel_tick = ticks.div128;
            default:    sel_tick = 1'b0;
        endcase
    end

    assign commit   = pend_q && ph_q && slow_tick;
    assign step     = run && sel_tick && !commit;
    assign hit      = step && (cnt_q == cmp_q);
    assign wrap     = step && (&cnt_q) && !hit;
    assign stop_req = hit && !cont_q;
    assign irq      = match_q && ien_q && (req_q == REQ_IRQ);

    // writable configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q <= 1'b0; ien_q <= 1'b0; req_q <= '0; cks_q <= '0;
        end else if (wr_ctl) begin
            cont_q <= wdata[CTL_CONT];
            ien_q  <= wdata[CTL_IEN];
            req_q  <= wdata[CTL_REQ +: 2];
            cks_q  <= wdata[2:0];
        end
    end

    // flags: clear on written zero, hardware set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0; ovfl_q <= 1'b0;
        end else begin
            match_q <= ((wr_ctl ? wdata[CTL_MATCH] : 1'b1) && match_q) || hit;
            ovfl_q  <= ((wr_ctl ? wdata[CTL_OVFL]  : 1'b1) && ovfl_q)  || wrap;
        end
    end

    // counter: delayed load, wrap to zero, or increment
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (commit)     cnt_q <= pval_q;
        else if (hit || wrap) cnt_q <= '0;
        else if (step)       cnt_q <= cnt_q + 1'b1;
    end

    // pending counter load waits for two slow pulses after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0; ph_q <= 1'b0; pval_q <= '0;
        end else if (wr_cnt) begin
            pend_q <= 1'b1; ph_q <= 1'b0; pval_q <= wdata[CNT_W-1:0];
        end else if (commit) begin
            pend_q <= 1'b0; ph_q <= 1'b0;
        end else if (pend_q && slow_tick) begin
            ph_q <= 1'b1;
        end
    end

    // compare register, all ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (wr_cmp) cmp_q <= wdata[CNT_W-1:0];
    end

    // assemble the control word for reads
    always_comb begin
        ctl_word               = '0;
        ctl_word[CTL_MATCH]    = match_q;
        ctl_word[CTL_OVFL]     = ovfl_q;
        ctl_word[CTL_CONT]     = cont_q;
        ctl_word[CTL_IEN]      = ien_q;
        ctl_word[CTL_REQ +: 2] = req_q;
        ctl_word[2:0]          = cks_q;
    end
endmodule

// File: rtl/cmtimer_top.sv
// Compare-match timer top: address decode, shared run-control word,
// read mux and one channel per NUM_CH. Assumes word-aligned accesses
// and NUM_CH channel blocks fitting below 2**ADDR_W.
module cmtimer_top
    import cmtimer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int BLK_W = ADDR_W - 4;

    tick_set_t                      ticks;
    logic [NUM_CH-1:0]              run_q, stop_req, pend_vec, blk_hit;
    logic [NUM_CH-1:0]              wr_ctl, wr_cnt, wr_cmp;
    logic [NUM_CH-1:0][DATA_W-1:0]  ctl_vec;
    logic [NUM_CH-1:0][CNT_W-1:0]   cnt_vec, cmp_vec;
    logic                           start_wr;
    logic [1:0]                     word_sel;

    assign start_wr = bus_we && (bus_addr == '0);
    assign word_sel = bus_addr[3:2];

    cmtimer_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ticks(ticks)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // decode this channel's block and word strobes
        assign blk_hit[c] = (bus_addr[ADDR_W-1:4] == BLK_W'(c + 1)) &&
                            (bus_addr[1:0] == 2'b00);
        assign wr_ctl[c]  = bus_we && blk_hit[c] && (word_sel == 2'd0);
        assign wr_cnt[c]  = bus_we && blk_hit[c] && (word_sel == 2'd1);
        assign wr_cmp[c]  = bus_we && blk_hit[c] && (word_sel == 2'd2);

        cmtimer_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .ticks(ticks), .slow_tick(slow_tick),
            .run(run_q[c]), .wr_ctl(wr_ctl[c]), .wr_cnt(wr_cnt[c]),
            .wr_cmp(wr_cmp[c]), .wdata(bus_wdata), .ctl_word(ctl_vec[c]),
            .cnt_q(cnt_vec[c]), .cmp_q(cmp_vec[c]), .pend_q(pend_vec[c]),
            .irq(irq[c]), .stop_req(stop_req[c])
        );
    end

    // shared run bits; a one-shot stop overrides a same-cycle write
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= (start_wr ? bus_wdata[NUM_CH-1:0] : run_q) & ~stop_req;
    end

    // read mux, unmapped addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata[NUM_CH-1:0] = run_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (blk_hit[c]) begin
                case (word_sel)
                    2'd0:    bus_rdata = ctl_vec[c];
                    2'd1:    bus_rdata = DATA_W'(cnt_vec[c]);
                    2'd2:    bus_rdata = DATA_W'(cmp_vec[c]);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmtimer_checker.sv
// Property checker for cmtimer_top, attached by bind. Observes ports and
// per-channel state vectors only; drives nothing.
module cmtimer_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic                          bus_we,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0]             run_q,
    input logic [NUM_CH-1:0]             pend_vec,
    input logic [NUM_CH-1:0][DATA_W-1:0] ctl_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_vec
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq == '0) && (run_q == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(16 + 16 * g);
        localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(20 + 16 * g);

        assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[g] && !pend_vec[g]) |=> $stable(cnt_vec[g]));

        assert_match_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctl_vec[g][15]) |-> (cnt_vec[g] == '0));

        assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run_q[g]) |-> ($past(bus_we && bus_addr == '0) || cnt_vec[g] == '0));

        assert_overflow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctl_vec[g][14]) |-> (cnt_vec[g] == '0));

        assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> (ctl_vec[g][15] && ctl_vec[g][7]));

        assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ctl_vec[g][15]) |-> $past(bus_we && bus_addr == CTL_A && !bus_wdata[15]));

        assert_load_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_vec[g]) |-> $past(bus_we && bus_addr == CNT_A));
    end
endmodule

bind cmtimer_top cmtimer_checker #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .irq(irq), .run_q(run_q), .pend_vec(pend_vec),
    .ctl_vec(ctl_vec), .cnt_vec(cnt_vec)
);

// File: tb/tb_cmtimer_top.sv
// Bench: behavioural reference model compared every clock, plus
// directed scenarios with hand-computed expectations.
module tb_cmtimer_top;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    cmtimer_top dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    // reference model state
    bit [31:0] m_cnt [NCH];
    bit [31:0] m_cmp [NCH];
    bit [31:0] m_cfg [NCH];
    bit        m_mf [NCH], m_of [NCH], m_run [NCH];
    bit        m_pend [NCH], m_ph [NCH];
    bit [31:0] m_pval [NCH];
    int        m_pre;

    function automatic bit mtick(bit [2:0] code, int pre, bit st);
        case (code)
            3'd7: return st;
            3'd4: return st && (pre % 8 == 7);
            3'd5: return st && (pre % 32 == 31);
            3'd6: return st && (pre % 128 == 127);
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit [31:0] mread(bit [7:0] a);
        int idx;
        if (a == 0) return {30'd0, m_run[1], m_run[0]};
        idx = a / 16 - 1;
        if (idx < 0 || idx >= NCH || a[1:0] != 0) return 0;
        case (a[3:2])
            2'd0: return m_cfg[idx] | (32'(m_mf[idx]) << 15) | (32'(m_of[idx]) << 14);
            2'd1: return m_cnt[idx];
            2'd2: return m_cmp[idx];
            default: return 0;
        endcase
    endfunction

    function automatic bit mirq(int c);
        return m_mf[c] && m_cfg[c][7] && (m_cfg[c][5:4] == 2'd2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0;
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_cmp[c] = 32'hFFFF_FFFF; m_cfg[c] = 0;
                m_mf[c] = 0; m_of[c] = 0; m_run[c] = 0;
                m_pend[c] = 0; m_ph[c] = 0; m_pval[c] = 0;
            end
        end else begin
            bit stop [NCH];
            for (int c = 0; c < NCH; c++) begin
                bit t, com, st, hit, wrp, wc;
                int base;
                base = 16 + 16 * c;
                wc  = bus_we && bus_addr == 8'(base);
                t   = mtick(m_cfg[c][2:0], m_pre, slow_tick);
                com = m_pend[c] && m_ph[c] && slow_tick;
                st  = m_run[c] && t && !com;
                hit = st && m_cnt[c] == m_cmp[c];
                wrp = st && m_cnt[c] == 32'hFFFF_FFFF && !hit;
                stop[c] = hit && !m_cfg[c][8];
                m_mf[c] = (wc ? (m_mf[c] && bus_wdata[15]) : m_mf[c]) || hit;
                m_of[c] = (wc ? (m_of[c] && bus_wdata[14]) : m_of[c]) || wrp;
                if (com) m_cnt[c] = m_pval[c];
                else if (hit || wrp) m_cnt[c] = 0;
                else if (st) m_cnt[c] = m_cnt[c] + 1;
                if (bus_we && bus_addr == 8'(base + 4)) begin
                    m_pend[c] = 1; m_ph[c] = 0; m_pval[c] = bus_wdata;
                end else if (com) begin
                    m_pend[c] = 0; m_ph[c] = 0;
                end else if (m_pend[c] && slow_tick) m_ph[c] = 1;
                if (wc) m_cfg[c] = bus_wdata & 32'h0000_01B7;
                if (bus_we && bus_addr == 8'(base + 8)) m_cmp[c] = bus_wdata;
            end
            for (int c = 0; c < NCH; c++) begin
                if (bus_we && bus_addr == 0) m_run[c] = bus_wdata[c];
                if (stop[c]) m_run[c] = 0;
            end
            if (slow_tick) m_pre = (m_pre + 1) % 128;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #3;
        if (!done) begin
            check("R2 model read", bus_rdata, mread(bus_addr));
            check("R8 model irq", {30'd0, irq}, {30'd0, mirq(1), mirq(0)});
        end
    end

    task automatic cyc(bit t);
        @(negedge clk);
        slow_tick = t; bus_we = 0;
        @(posedge clk); #1;
    endtask

    task automatic wr(bit [7:0] a, bit [31:0] d, bit t);
        @(negedge clk);
        slow_tick = t; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 0;
    endtask

    task automatic rd(bit [7:0] a, bit [31:0] e, string tag);
        bus_addr = a; #1;
        check(tag, bus_rdata, e);
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        rd(8'h00, 0, "R1 run word");
        rd(8'h10, 0, "R1 ctl0");
        rd(8'h14, 0, "R1 cnt0");
        rd(8'h18, 32'hFFFF_FFFF, "R1 cmp0");
        rd(8'h28, 32'hFFFF_FFFF, "R1 cmp1");
        check("R1 irq", {30'd0, irq}, 0);
        // R2 writable mask and unmapped reads
        wr(8'h10, 32'hFFFF_FFFF, 1);
        rd(8'h10, 32'h0000_01B7, "R2 ctl mask");
        rd(8'h0C, 0, "R2 unmapped 0x0C");
        rd(8'h1C, 0, "R2 unmapped 0x1C");
        // R5 match period
        wr(8'h18, 4, 1);
        wr(8'h10, 32'h01A7, 1);
        wr(8'h00, 1, 1);
        repeat (4) cyc(1);
        rd(8'h14, 4, "R5 count before match");
        cyc(1);
        rd(8'h14, 0, "R5 wrap to zero");
        rd(8'h10, 32'h81A7, "R5 match flag");
        check("R8 irq on match", {30'd0, irq}, 1);
        // R9 clear, collision, write-one
        wr(8'h10, 32'h01A7, 1);
        rd(8'h10, 32'h01A7, "R9 cleared");
        repeat (3) cyc(1);
        wr(8'h10, 32'h01A7, 1);
        rd(8'h10, 32'h81A7, "R9 set wins over clear");
        rd(8'h14, 0, "R9 collision count");
        wr(8'h10, 32'h81A7, 1);
        rd(8'h10, 32'h81A7, "R9 write one keeps");
        wr(8'h10, 32'h01A7, 1);
        wr(8'h10, 32'h81A7, 1);
        rd(8'h10, 32'h01A7, "R9 write one no set");
        // R8 request type other than 2
        wr(8'h10, 32'h0197, 1);
        cyc(1);
        rd(8'h10, 32'h8197, "R8 flag with type 1");
        check("R8 irq low for type 1", {30'd0, irq}, 0);
        wr(8'h10, 32'h01A7, 1);
        // R3 stop holds
        wr(8'h00, 0, 1);
        rd(8'h00, 0, "R3 stopped");
        rd(8'h14, 2, "R3 count at stop");
        repeat (5) cyc(1);
        rd(8'h14, 2, "R3 hold while stopped");
        // R6 one-shot on channel 1
        wr(8'h28, 2, 1);
        wr(8'h20, 32'h00A7, 1);
        wr(8'h00, 2, 1);
        rd(8'h00, 2, "R3 only channel 1 runs");
        repeat (2) cyc(1);
        rd(8'h24, 2, "R6 ch1 before match");
        cyc(1);
        rd(8'h00, 0, "R6 one-shot stop");
        rd(8'h20, 32'h80A7, "R6 ch1 flag");
        check("R8 ch1 irq", {30'd0, irq}, 2);
        repeat (3) cyc(1);
        rd(8'h24, 0, "R6 stays stopped");
        rd(8'h14, 2, "R3 ch0 untouched");
        // R3 resume
        wr(8'h00, 1, 1);
        cyc(1);
        rd(8'h14, 3, "R3 resume from held");
        wr(8'h00, 0, 1);
        rd(8'h14, 4, "R3 last count");
        // R4 prescaler codes
        wr(8'h18, 32'hFFFF_FFFF, 0);
        wr(8'h10, 32'h01A4, 0);
        wr(8'h00, 1, 0);
        repeat (64) cyc(1);
        rd(8'h14, 12, "R4 div8");
        wr(8'h00, 0, 0); wr(8'h10, 32'h01A5, 0); wr(8'h00, 1, 0);
        repeat (64) cyc(1);
        rd(8'h14, 14, "R4 div32");
        wr(8'h00, 0, 0); wr(8'h10, 32'h01A6, 0); wr(8'h00, 1, 0);
        repeat (256) cyc(1);
        rd(8'h14, 16, "R4 div128");
        wr(8'h00, 0, 0); wr(8'h10, 32'h01A0, 0); wr(8'h00, 1, 0);
        repeat (32) cyc(1);
        rd(8'h14, 16, "R4 code0 no tick");
        wr(8'h10, 32'h01A7, 0);
        repeat (5) cyc(0);
        rd(8'h14, 16, "R4 no slow pulse");
        // R10 load latency, R7 overflow
        wr(8'h18, 5, 0);
        wr(8'h14, 32'hFFFF_FFFD, 1);
        rd(8'h14, 17, "R10 old value counts");
        repeat (3) cyc(0);
        rd(8'h14, 17, "R10 waits for pulses");
        cyc(1);
        rd(8'h14, 18, "R10 first pulse old");
        cyc(1);
        rd(8'h14, 32'hFFFF_FFFD, "R10 commit no increment");
        repeat (2) cyc(1);
        rd(8'h14, 32'hFFFF_FFFF, "R7 at top");
        cyc(1);
        rd(8'h14, 0, "R7 wrap");
        rd(8'h10, 32'h41A7, "R7 overflow flag");
        wr(8'h10, 32'h01A7, 1);
        rd(8'h10, 32'h01A7, "R9 overflow cleared");
        repeat (4) cyc(1);
        finish_up();
    end
endmodule